// File: doc/BRIEF.md
# Partitioned Real-Time Cache Set Allocator

This block decides which set of a direct-mapped cache an access may fill, so that critical tasks cannot have their lines evicted by other tasks. The cache sets are split into one shared pool at the bottom of the index space and a number of equally sized private regions above it. A critical task claims a private region with an allocate command and hands it back with a release command. Each region stays with its owner until that release. Non-critical tasks never receive a region.

For each access the block takes a task ID, a word address and a hint asking for private placement, and it returns a set index, a permitted flag and a flag that shows the index lies in the task's own region. The index is computed combinationally from the current ownership table. A mode input turns partitioning off. In that mode the block behaves as a plain direct-mapped index, and addresses that differ by a multiple of the cache size collide as usual. Tag storage, data arrays and refill are handled elsewhere.

Top module: `pca_top`

## Requirements
- R1: After reset every private region is free, so no access is placed in a private region until a new allocation is made.
- R2: An allocate command with the critical flag set gives the requesting task the free region with the lowest number, when such a region exists and the task owns none. The ownership is visible from the first clock edge after the command.
- R3: An allocate from a critical task raises cmd_err and changes no ownership when every region is taken or when the task already owns a region.
- R4: An allocate with the critical flag clear changes no ownership and raises no error. That task's accesses keep landing in the shared pool.
- R5: A release frees the region owned by cmd_tid from the next clock edge, and the region can then be allocated to another task. A release from a task that owns nothing raises cmd_err.
- R6: With partitioning on, the private hint set and the task owning region r, set_idx = COMMON_SETS + r*REGION_SETS + (blk mod REGION_SETS), and private_hit is 1. Here blk = acc_addr >> 6 (64-word blocks).
- R7: With partitioning on, an access whose hint is clear or whose task owns no region gets set_idx = blk mod COMMON_SETS, and private_hit is 0.
- R8: With partitioning off, set_idx = blk mod 16 for the default 1K-word, 16-set cache, and private_hit is 0. Word addresses 1024 and 8192 therefore both map to set 0.
- R9: permitted is equal to acc_valid. A qualified access may always fill its returned set.
- R10: The mapping follows the access inputs within the same cycle. A command changes the mapping only after the clock edge that samples it.
- R11: cmd_err is a single-cycle pulse during the cycle after the failing command, and it is low in every other cycle. cmd_kind uses 0 for allocate and 1 for release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 1 | 0 allocate, 1 release |
| cmd_tid | input | 4 | Task issuing the command |
| cmd_crit | input | 1 | Task is critical (allocate only) |
| cmd_err | output | 1 | Command refused, one cycle after it |
| part_en | input | 1 | 1 partitioned indexing, 0 plain direct mapped |
| acc_valid | input | 1 | Access qualifier |
| acc_tid | input | 4 | Task making the access |
| acc_addr | input | 16 | Word address of the access |
| acc_priv | input | 1 | Request placement in own private region |
| set_idx | output | 4 | Cache set the access may use |
| permitted | output | 1 | Fill into set_idx is allowed |
| private_hit | output | 1 | set_idx lies in the task's own region |

## Verification
The access results are combinational, so the bench drives the access fields and compares set_idx, permitted and private_hit one time unit later in the same cycle. Commands are driven on a falling edge. cmd_err and the new ownership are read on the next falling edge, after the single register stage has captured them. In one directed case the mapping is also read right after the command is driven, before the rising edge, to show that it has not changed yet. The cmd_err low level is then read one cycle further on, so the one-cycle error pulse is checked from both sides.

// File: rtl/pca_pkg.sv
package pca_pkg;

    typedef enum logic {
        CMD_ALLOC   = 1'b0,
        CMD_RELEASE = 1'b1
    } cmd_kind_e;

    typedef enum logic [1:0] {
        MAP_FLAT    = 2'd0,
        MAP_SHARED  = 2'd1,
        MAP_PRIVATE = 2'd2
    } map_mode_e;

    // block number folded into a region of n sets
    function automatic logic [31:0] fold_blk(input logic [31:0] blk, input int unsigned n);
        return blk % n;
    endfunction

    // first set of private region r
    function automatic logic [31:0] region_base(input int unsigned r,
                                                input int unsigned common_sets,
                                                input int unsigned region_sets);
        return 32'(common_sets + r * region_sets);
    endfunction

endpackage

// File: rtl/pca_first_free.sv
module pca_first_free #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] free_vec,
    output logic [N-1:0] grant,
    output logic         any_free
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            assign grant[i]  = free_vec[i] & ~seen[i];
            assign seen[i+1] = seen[i] | free_vec[i];
        end
    endgenerate

    assign any_free = seen[N];

endmodule

// File: rtl/pca_owner_tbl.sv
module pca_owner_tbl
    import pca_pkg::*;
#(
    parameter int unsigned NREG  = 2,
    parameter int unsigned TID_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic                  cmd_kind,
    input  logic [TID_W-1:0]      cmd_tid,
    input  logic                  cmd_crit,
    output logic                  cmd_err,
    output logic [NREG-1:0]       own_vld,
    output logic [NREG*TID_W-1:0] own_tid
);
    cmd_kind_e              kind;
    logic [NREG-1:0]        hit;
    logic [NREG-1:0]        grant;
    logic                   any_free;
    logic                   any_hit;
    logic [NREG-1:0]        vld_n;
    logic [NREG*TID_W-1:0]  tid_n;
    logic                   err_n;

    assign kind = cmd_kind_e'(cmd_kind);

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_match
            assign hit[r] = own_vld[r] && (own_tid[r*TID_W +: TID_W] == cmd_tid);
        end
    endgenerate

    assign any_hit = |hit;

    pca_first_free #(.N(NREG)) u_free (
        .free_vec (~own_vld),
        .grant    (grant),
        .any_free (any_free)
    );

    always_comb begin
        vld_n = own_vld;
        tid_n = own_tid;
        err_n = 1'b0;
        if (cmd_valid) begin
            case (kind)
                CMD_ALLOC: begin
                    if (cmd_crit) begin
                        if (any_hit || !any_free) begin
                            err_n = 1'b1;
                        end else begin
                            for (int k = 0; k < int'(NREG); k++) begin
                                if (grant[k]) begin
                                    vld_n[k] = 1'b1;
                                    tid_n[k*TID_W +: TID_W] = cmd_tid;
                                end
                            end
                        end
                    end
                end
                CMD_RELEASE: begin
                    if (!any_hit) err_n = 1'b1;
                    else          vld_n = own_vld & ~hit;
                end
                default: err_n = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_vld <= '0;
            own_tid <= '0;
            cmd_err <= 1'b0;
        end else begin
            own_vld <= vld_n;
            own_tid <= tid_n;
            cmd_err <= err_n;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> own_vld == '0); // R1

    AST_ALLOC_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 1'b0) |=> $countones(own_vld & ~$past(own_vld)) <= 1); // R2

    AST_ERR_KEEPS_TABLE: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> own_vld == $past(own_vld)); // R3

    AST_NONCRIT_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 1'b0 && !cmd_crit) |=> (own_vld == $past(own_vld)) && !cmd_err); // R4

    AST_RELEASE_NO_ADD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 1'b1) |=> (own_vld & ~$past(own_vld)) == '0); // R5

    AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid)); // R11

    generate
        for (r = 0; r < NREG; r++) begin : g_uniq
            logic [NREG-1:0] same;
            for (genvar j = 0; j < NREG; j++) begin : g_cmp
                assign same[j] = own_vld[r] && own_vld[j] &&
                                 (own_tid[j*TID_W +: TID_W] == own_tid[r*TID_W +: TID_W]);
            end
            AST_ONE_REGION_PER_TASK: assert property (@(posedge clk) disable iff (rst)
                $countones(same) <= 1); // R3
        end
    endgenerate

endmodule

// File: rtl/pca_set_map.sv
module pca_set_map
    import pca_pkg::*;
#(
    parameter int unsigned NREG        = 2,
    parameter int unsigned TID_W       = 4,
    parameter int unsigned REGION_SETS = 4,
    parameter int unsigned COMMON_SETS = 8,
    parameter int unsigned OFF_W       = 6,
    parameter int unsigned ADDR_W      = 16,
    localparam int unsigned TOTAL_SETS = NREG * REGION_SETS + COMMON_SETS,
    localparam int unsigned SET_W      = $clog2(TOTAL_SETS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  part_en,
    input  logic                  acc_valid,
    input  logic [TID_W-1:0]      acc_tid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_priv,
    input  logic [NREG-1:0]       own_vld,
    input  logic [NREG*TID_W-1:0] own_tid,
    output logic [SET_W-1:0]      set_idx,
    output logic                  permitted,
    output logic                  private_hit
);
    logic [NREG-1:0] owns;
    logic [31:0]     blk;
    logic [31:0]     base;
    logic [31:0]     idx32;
    map_mode_e       mode;

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_own
            assign owns[r] = own_vld[r] && (own_tid[r*TID_W +: TID_W] == acc_tid);
        end
    endgenerate

    assign blk = 32'(acc_addr) >> OFF_W;

    always_comb begin
        base = region_base(0, COMMON_SETS, REGION_SETS);
        for (int k = 0; k < int'(NREG); k++) begin
            if (owns[k]) base = region_base(k, COMMON_SETS, REGION_SETS);
        end
    end

    always_comb begin
        if (!part_en)                 mode = MAP_FLAT;
        else if (acc_priv && |owns)   mode = MAP_PRIVATE;
        else                          mode = MAP_SHARED;
    end

    always_comb begin
        case (mode)
            MAP_PRIVATE: idx32 = base + fold_blk(blk, REGION_SETS);
            MAP_SHARED:  idx32 = fold_blk(blk, COMMON_SETS);
            default:     idx32 = fold_blk(blk, TOTAL_SETS);
        endcase
    end

    assign set_idx     = SET_W'(idx32);
    assign private_hit = (mode == MAP_PRIVATE);
    assign permitted   = acc_valid;

    AST_PRIV_IN_REGIONS: assert property (@(posedge clk) disable iff (rst)
        (part_en && private_hit) |-> 32'(set_idx) >= COMMON_SETS); // R6

    AST_PRIV_NEEDS_HINT: assert property (@(posedge clk) disable iff (rst)
        private_hit |-> (acc_priv && part_en)); // R6

    AST_SHARED_IN_POOL: assert property (@(posedge clk) disable iff (rst)
        (part_en && !private_hit) |-> 32'(set_idx) < COMMON_SETS); // R7

    AST_FLAT_NO_PRIV: assert property (@(posedge clk) disable iff (rst)
        !part_en |-> !private_hit); // R8

endmodule

// File: rtl/pca_top.sv
module pca_top #(
    parameter int unsigned NREG        = 2,
    parameter int unsigned TID_W       = 4,
    parameter int unsigned REGION_SETS = 4,
    parameter int unsigned COMMON_SETS = 8,
    parameter int unsigned OFF_W       = 6,
    parameter int unsigned ADDR_W      = 16,
    localparam int unsigned TOTAL_SETS = NREG * REGION_SETS + COMMON_SETS,
    localparam int unsigned SET_W      = $clog2(TOTAL_SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_kind,
    input  logic [TID_W-1:0]  cmd_tid,
    input  logic              cmd_crit,
    output logic              cmd_err,
    input  logic              part_en,
    input  logic              acc_valid,
    input  logic [TID_W-1:0]  acc_tid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_priv,
    output logic [SET_W-1:0]  set_idx,
    output logic              permitted,
    output logic              private_hit
);
    logic [NREG-1:0]       own_vld;
    logic [NREG*TID_W-1:0] own_tid;

    pca_owner_tbl #(.NREG(NREG), .TID_W(TID_W)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_tid   (cmd_tid),
        .cmd_crit  (cmd_crit),
        .cmd_err   (cmd_err),
        .own_vld   (own_vld),
        .own_tid   (own_tid)
    );

    pca_set_map #(
        .NREG        (NREG),
        .TID_W       (TID_W),
        .REGION_SETS (REGION_SETS),
        .COMMON_SETS (COMMON_SETS),
        .OFF_W       (OFF_W),
        .ADDR_W      (ADDR_W)
    ) u_map (
        .clk         (clk),
        .rst         (rst),
        .part_en     (part_en),
        .acc_valid   (acc_valid),
        .acc_tid     (acc_tid),
        .acc_addr    (acc_addr),
        .acc_priv    (acc_priv),
        .own_vld     (own_vld),
        .own_tid     (own_tid),
        .set_idx     (set_idx),
        .permitted   (permitted),
        .private_hit (private_hit)
    );

endmodule

// File: tb/sim_pca_top.sv
module sim_pca_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_kind, cmd_crit;
    logic [3:0]  cmd_tid;
    logic        cmd_err;
    logic        part_en, acc_valid, acc_priv;
    logic [3:0]  acc_tid;
    logic [15:0] acc_addr;
    logic [3:0]  set_idx;
    logic        permitted, private_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pca_top u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_tid(cmd_tid),
        .cmd_crit(cmd_crit), .cmd_err(cmd_err),
        .part_en(part_en), .acc_valid(acc_valid), .acc_tid(acc_tid),
        .acc_addr(acc_addr), .acc_priv(acc_priv),
        .set_idx(set_idx), .permitted(permitted), .private_hit(private_hit)
    );

    // {part_en, tid[3:0], priv, addr[15:0], exp_idx[3:0], exp_priv}
    // task 3 owns region 0 (sets 8..11), task 5 owns region 1 (sets 12..15)
    localparam logic [26:0] VEC [12] = '{
        {1'b0, 4'd3, 1'b1, 16'd1024,  4'd0,  1'b0},  // R8 collide
        {1'b0, 4'd7, 1'b0, 16'd8192,  4'd0,  1'b0},  // R8 collide
        {1'b0, 4'd3, 1'b0, 16'd960,   4'd15, 1'b0},  // R8
        {1'b1, 4'd3, 1'b1, 16'd1024,  4'd8,  1'b1},  // R6
        {1'b1, 4'd7, 1'b0, 16'd8192,  4'd0,  1'b0},  // R7
        {1'b1, 4'd5, 1'b1, 16'd192,   4'd15, 1'b1},  // R6
        {1'b1, 4'd5, 1'b0, 16'd192,   4'd3,  1'b0},  // R7 hint clear
        {1'b1, 4'd7, 1'b1, 16'd320,   4'd5,  1'b0},  // R7 no owner
        {1'b1, 4'd3, 1'b1, 16'hFFFF,  4'd11, 1'b1},  // R6 top address
        {1'b1, 4'd3, 1'b0, 16'h0FFF,  4'd7,  1'b0},  // R7
        {1'b1, 4'd5, 1'b1, 16'h8000,  4'd12, 1'b1},  // R6
        {1'b1, 4'd0, 1'b1, 16'd64,    4'd1,  1'b0}   // R7
    };

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic access(logic pe, logic [3:0] tid, logic pv, logic [15:0] a);
        part_en = pe; acc_tid = tid; acc_priv = pv; acc_addr = a; acc_valid = 1'b1;
        #1;
    endtask

    task automatic map_chk(string req, logic pe, logic [3:0] tid, logic pv,
                           logic [15:0] a, int eidx, int epriv);
        access(pe, tid, pv, a);
        chk(req, "set_idx", int'(set_idx), eidx);
        chk(req, "private_hit", int'(private_hit), epriv);
    endtask

    // drive at falling edge, returns at the next falling edge with cmd dropped
    task automatic command(logic kind, logic [3:0] tid, logic crit);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_tid = tid; cmd_crit = crit;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_kind = 1'b0; cmd_tid = '0; cmd_crit = 1'b0;
        part_en = 1'b1; acc_valid = 1'b0; acc_tid = '0; acc_addr = '0; acc_priv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R11", "cmd_err after reset", int'(cmd_err), 0);
        map_chk("R1", 1'b1, 4'd3, 1'b1, 16'd1024, 0, 0);

        // R10 / R2 allocation timing
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 1'b0; cmd_tid = 4'd3; cmd_crit = 1'b1;
        map_chk("R10 before edge", 1'b1, 4'd3, 1'b1, 16'd1024, 0, 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2", "cmd_err", int'(cmd_err), 0);
        map_chk("R2 region0", 1'b1, 4'd3, 1'b1, 16'd1024, 8, 1);
        command(1'b0, 4'd5, 1'b1);
        chk("R2", "cmd_err", int'(cmd_err), 0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            logic [26:0] v;
            v = VEC[i];
            map_chk($sformatf("R6/R7/R8 vec%0d", i), v[26], v[25:22], v[21], v[20:5],
                    int'(v[4:1]), int'(v[0]));
        end

        // R9 permitted
        access(1'b1, 4'd3, 1'b1, 16'd0);
        acc_valid = 1'b0; #1;
        chk("R9", "permitted low", int'(permitted), 0);
        acc_valid = 1'b1; #1;
        chk("R9", "permitted high", int'(permitted), 1);

        // R3 all regions taken
        command(1'b0, 4'd9, 1'b1);
        chk("R3 full", "cmd_err", int'(cmd_err), 1);
        map_chk("R3 full", 1'b1, 4'd9, 1'b1, 16'd64, 1, 0);
        @(negedge clk);
        chk("R11", "cmd_err pulse ends", int'(cmd_err), 0);

        // R5 release and release of non-owner
        command(1'b1, 4'd3, 1'b0);
        chk("R5", "cmd_err", int'(cmd_err), 0);
        map_chk("R5 freed", 1'b1, 4'd3, 1'b1, 16'd1024, 0, 0);
        command(1'b1, 4'd3, 1'b0);
        chk("R5 non-owner", "cmd_err", int'(cmd_err), 1);

        // R4 non-critical
        command(1'b0, 4'd6, 1'b0);
        chk("R4", "cmd_err", int'(cmd_err), 0);
        map_chk("R4", 1'b1, 4'd6, 1'b1, 16'd192, 3, 0);

        // R3 duplicate with a region still free
        command(1'b0, 4'd5, 1'b1);
        chk("R3 dup", "cmd_err", int'(cmd_err), 1);
        map_chk("R3 dup", 1'b1, 4'd5, 1'b1, 16'd192, 15, 1);

        // R5 reuse of freed region 0
        command(1'b0, 4'd9, 1'b1);
        chk("R5 reuse", "cmd_err", int'(cmd_err), 0);
        map_chk("R5 reuse", 1'b1, 4'd9, 1'b1, 16'd128, 10, 1);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        map_chk("R1 rerun", 1'b1, 4'd9, 1'b1, 16'd128, 2, 0);
        map_chk("R1 rerun", 1'b1, 4'd5, 1'b1, 16'd192, 3, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule